// File: doc/BRIEF.md
# Dual-Edge Input Capture with Edge Prescaler

This block timestamps transitions of a single external input against a free-running timer count supplied from outside. The input is first brought into the clock domain by a short synchroniser. From there it feeds two paths. The first path is the synchronised input itself. The second is an edge prescaler: it counts both rising and falling transitions and emits a one-cycle pulse each time a programmable number of transitions has been seen.

A source select picks which of the two paths feeds the capture logic. The capture logic is a pair of capture slots driven by an arming sequencer. Once armed, slot A waits for its qualifying transition and latches the timer count. Control then passes to slot B, which latches the next qualifying transition. In one-shot mode the sequencer disarms after slot B. In continuous mode it returns to slot A.

Each slot has a 2-bit edge qualifier, a capture register, a sticky flag and an interrupt enable. The prescaler is useful for thinning out a fast signal so that only every Nth transition is timestamped. It can also raise an interrupt after N events.

Top module: `edge_capture`

## Requirements
- R1: A transition on `pin_in` that qualifies for the slot waiting its turn makes that slot latch the value of `tstamp` present at the third rising clock edge after the transition. The slot's flag rises at that same edge. A capture register changes only when a capture happens.
- R2: The edge qualifiers `edge_a` and `edge_b` use this code: 2'b00 means the slot never captures, 2'b01 means falling transitions, 2'b10 means rising transitions, and 2'b11 means either transition.
- R3: After a one-cycle `arm_start` pulse, captures alternate. Slot A captures first, then slot B. With `one_shot` low, the next qualifying event goes to slot A again.
- R4: With `one_shot` high, `armed` falls at the edge where slot B captures. No further capture happens until the next `arm_start`.
- R5: `flag_a` and `flag_b` stay high once set. A one-cycle pulse on `clr_a` or `clr_b` clears the matching flag at the next clock edge.
- R6: `irq_a` is high exactly when `flag_a` and `ie_a` are both high. `irq_b` is high exactly when `flag_b` and `ie_b` are both high.
- R7: While `pre_en` is high, `edge_cnt` increments once for every rising and every falling transition of the synchronised input. While `pre_en` is low, `edge_cnt` is held at zero.
- R8: When a counted transition would bring `edge_cnt` to `pre_cmp`, the prescaler emits a one-cycle pulse and `edge_cnt` returns to zero. A `pre_cmp` of 0 therefore gives one pulse per 256 transitions.
- R9: With `src_sel` at 0 the slots watch the synchronised pin. With `src_sel` at 1 they watch the prescaler pulse, and that pulse counts as the event for any qualifier other than 2'b00. The capture from a pulse lands one clock edge after the pulse, which is four edges after the transition that completed the count.
- R10: After reset, both flags, both interrupts, both capture registers, `edge_cnt` and `armed` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous signal to timestamp |
| tstamp | input | 16 | Free-running timer count to latch |
| src_sel | input | 1 | Capture source: 0 is the pin, 1 is the prescaler pulse |
| pre_en | input | 1 | Prescaler edge-counter enable |
| pre_cmp | input | 8 | Prescaler compare value (0 means 256) |
| edge_a | input | 2 | Edge qualifier for slot A |
| edge_b | input | 2 | Edge qualifier for slot B |
| one_shot | input | 1 | 1 stops after slot B, 0 keeps alternating |
| arm_start | input | 1 | One-cycle pulse that arms the sequence at slot A |
| arm_stop | input | 1 | One-cycle pulse that disarms |
| ie_a | input | 1 | Interrupt enable, slot A |
| ie_b | input | 1 | Interrupt enable, slot B |
| clr_a | input | 1 | Write-one-to-clear pulse for `flag_a` |
| clr_b | input | 1 | Write-one-to-clear pulse for `flag_b` |
| cap_a | output | 16 | Capture register, slot A |
| cap_b | output | 16 | Capture register, slot B |
| flag_a | output | 1 | Capture flag, slot A |
| flag_b | output | 1 | Capture flag, slot B |
| irq_a | output | 1 | Interrupt, slot A |
| irq_b | output | 1 | Interrupt, slot B |
| edge_cnt | output | 8 | Current prescaler count |
| armed | output | 1 | Sequencer is armed |

## Verification
A pin transition crosses two synchroniser flops and one previous-sample flop. The capture register, the flag and `edge_cnt` therefore change at the third clock edge after it. A capture fed by the prescaler pulse adds one more edge and lands at the fourth. The bench holds `tstamp` constant for several cycles around every stimulus, so the expected timestamp does not depend on the exact capture edge. It then waits four or five edges before it samples, always half a cycle away from the active edge. Between successive pin toggles it leaves two edges, so the synchroniser sees every level.

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int CNT_W = 8,
  parameter int TS_W  = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic [TS_W-1:0]  tstamp,
  input  logic             src_sel,
  input  logic             pre_en,
  input  logic [CNT_W-1:0] pre_cmp,
  input  logic [1:0]       edge_a,
  input  logic [1:0]       edge_b,
  input  logic             one_shot,
  input  logic             arm_start,
  input  logic             arm_stop,
  input  logic             ie_a,
  input  logic             ie_b,
  input  logic             clr_a,
  input  logic             clr_b,
  output logic [TS_W-1:0]  cap_a,
  output logic [TS_W-1:0]  cap_b,
  output logic             flag_a,
  output logic             flag_b,
  output logic             irq_a,
  output logic             irq_b,
  output logic [CNT_W-1:0] edge_cnt,
  output logic             armed
);

  logic [SYNC:0] sh;
  logic pulse, slot;

  wire cur  = sh[SYNC-1];
  wire prev = sh[SYNC];
  wire rise = cur & ~prev;
  wire fall = ~cur & prev;
  wire any_edge = rise | fall;

  wire [CNT_W-1:0] cnt_inc = edge_cnt + 1'b1;
  wire hit = any_edge && (cnt_inc == pre_cmp);

  function automatic logic qualify(input logic [1:0] sel, input logic r, input logic f,
                                   input logic p, input logic use_p);
    if (sel == 2'b00) return 1'b0;
    if (use_p)        return p;
    return (sel[1] & r) | (sel[0] & f);
  endfunction

  wire ev_a = qualify(edge_a, rise, fall, pulse, src_sel);
  wire ev_b = qualify(edge_b, rise, fall, pulse, src_sel);
  wire go_a = armed && !slot && ev_a;
  wire go_b = armed &&  slot && ev_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], pin_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_cnt <= '0;
      pulse    <= 1'b0;
    end else begin
      pulse <= pre_en && hit;
      if (!pre_en)       edge_cnt <= '0;
      else if (any_edge) edge_cnt <= hit ? '0 : cnt_inc;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      slot  <= 1'b0;
    end else if (arm_stop) begin
      armed <= 1'b0;
      slot  <= 1'b0;
    end else if (arm_start && !armed) begin
      armed <= 1'b1;
      slot  <= 1'b0;
    end else if (go_a) begin
      slot <= 1'b1;
    end else if (go_b) begin
      slot <= 1'b0;
      if (one_shot) armed <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_a  <= '0;
      cap_b  <= '0;
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      if (go_a) cap_a <= tstamp;
      if (go_b) cap_b <= tstamp;
      flag_a <= go_a | (flag_a & ~clr_a);
      flag_b <= go_b | (flag_b & ~clr_b);
    end

  assign irq_a = flag_a & ie_a;
  assign irq_b = flag_b & ie_b;

endmodule

module edge_capture_chk #(
  parameter int CNT_W = 8,
  parameter int TS_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pre_en,
  input logic             clr_a,
  input logic             clr_b,
  input logic             ie_a,
  input logic             one_shot,
  input logic [TS_W-1:0]  cap_a,
  input logic [TS_W-1:0]  cap_b,
  input logic             flag_a,
  input logic             flag_b,
  input logic             irq_a,
  input logic [CNT_W-1:0] edge_cnt,
  input logic             armed
);

  AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n) flag_a && !clr_a |=> flag_a); // R5
  AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n) flag_b && !clr_b |=> flag_b); // R5
  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !pre_en |=> edge_cnt == '0); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |=> (edge_cnt == $past(edge_cnt) || edge_cnt == CNT_W'($past(edge_cnt) + 1'b1) || edge_cnt == '0)); // R8
  AST_CAP_A_ONLY_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cap_a != $past(cap_a) |-> flag_a); // R1
  AST_CAP_B_ONLY_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cap_b != $past(cap_b) |-> flag_b); // R1
  AST_IRQ_A_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq_a |-> flag_a && ie_a); // R6
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) && $past(one_shot) && !$past(flag_b) |-> !armed); // R4

endmodule

bind edge_capture edge_capture_chk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .clr_a(clr_a), .clr_b(clr_b),
  .ie_a(ie_a), .one_shot(one_shot), .cap_a(cap_a), .cap_b(cap_b),
  .flag_a(flag_a), .flag_b(flag_b), .irq_a(irq_a), .edge_cnt(edge_cnt), .armed(armed)
);

// File: tb/sim_edge_capture.sv
module sim_edge_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0;
  logic [15:0] tstamp = '0;
  logic src_sel = 0, pre_en = 0, one_shot = 0, arm_start = 0, arm_stop = 0;
  logic [7:0] pre_cmp = '0;
  logic [1:0] edge_a = 2'b10, edge_b = 2'b01;
  logic ie_a = 0, ie_b = 0, clr_a = 0, clr_b = 0;
  logic [15:0] cap_a, cap_b;
  logic flag_a, flag_b, irq_a, irq_b, armed;
  logic [7:0] edge_cnt;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  edge_capture u0 (.*);

  // {pin, tstamp[15:0], flag_a, flag_b, cap_a[15:0], cap_b[15:0]}
  localparam logic [50:0] VEC [5] = '{
    {1'b1, 16'h0100, 1'b1, 1'b0, 16'h0100, 16'h0000},
    {1'b0, 16'h0200, 1'b1, 1'b1, 16'h0100, 16'h0200},
    {1'b1, 16'h0300, 1'b1, 1'b1, 16'h0300, 16'h0200},
    {1'b0, 16'h0400, 1'b1, 1'b1, 16'h0300, 16'h0400},
    {1'b1, 16'h0500, 1'b1, 1'b1, 16'h0500, 16'h0400}
  };

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_in = 1'b0; src_sel = 0; pre_en = 0; one_shot = 0;
    arm_start = 0; arm_stop = 0; ie_a = 0; ie_b = 0; clr_a = 0; clr_b = 0;
    pre_cmp = '0; edge_a = 2'b10; edge_b = 2'b01; tstamp = '0;
    tick(2); rst_n = 1'b1; tick(3);
  endtask

  task automatic arm();
    arm_start = 1'b1; tick(); arm_start = 1'b0; tick();
  endtask

  task automatic drive(input logic v, input logic [15:0] ts);
    tstamp = ts; pin_in = v; tick(4);
  endtask

  task automatic toggle();
    pin_in = ~pin_in; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R10 flags", {flag_a, flag_b, irq_a, irq_b}, 0);
    chk("R10 caps", {cap_a, cap_b}, 0);
    chk("R10 cnt/armed", {edge_cnt, armed}, 0);

    // R1 R3: continuous alternation, A rising, B falling
    arm();
    chk("R3 armed", armed, 1);
    foreach (VEC[i]) begin
      drive(VEC[i][50], VEC[i][49:34]);
      chk("R3 flag_a", flag_a, VEC[i][33]);
      chk("R3 flag_b", flag_b, VEC[i][32]);
      chk("R1 cap_a", cap_a, VEC[i][31:16]);
      chk("R1 cap_b", cap_b, VEC[i][15:0]);
    end

    // R1 latency: capture at third edge
    do_reset(); arm();
    tstamp = 16'h0AAA; pin_in = 1'b1; tick(2);
    chk("R1 not yet", flag_a, 0);
    tick();
    chk("R1 third edge flag", flag_a, 1);
    chk("R1 third edge cap", cap_a, 16'h0AAA);

    // R6 and R5
    chk("R6 irq off", irq_a, 0);
    ie_a = 1'b1; #1;
    chk("R6 irq on", irq_a, 1);
    tick(3);
    chk("R5 sticky", flag_a, 1);
    clr_a = 1'b1; tick(); clr_a = 1'b0;
    chk("R5 cleared", flag_a, 0);
    chk("R6 irq after clear", irq_a, 0);

    // R4 one-shot
    do_reset(); one_shot = 1'b1; arm();
    drive(1'b1, 16'h1111);
    drive(1'b0, 16'h2222);
    chk("R4 cap_b", cap_b, 16'h2222);
    chk("R4 disarmed", armed, 0);
    drive(1'b1, 16'h3333);
    chk("R4 no recapture", cap_a, 16'h1111);

    // R2 code 00 disables
    do_reset(); edge_a = 2'b00; arm();
    drive(1'b1, 16'h0111);
    drive(1'b0, 16'h0222);
    chk("R2 00 flag", flag_a, 0);
    chk("R2 00 cap", cap_a, 0);

    // R2 code 01 falling only
    do_reset(); edge_a = 2'b01; arm();
    drive(1'b1, 16'h0333);
    chk("R2 01 ignores rise", flag_a, 0);
    drive(1'b0, 16'h0444);
    chk("R2 01 fall", cap_a, 16'h0444);

    // R2 code 11 any edge
    do_reset(); edge_a = 2'b11; edge_b = 2'b11; arm();
    drive(1'b1, 16'h0555);
    drive(1'b0, 16'h0666);
    chk("R2 11 rise", cap_a, 16'h0555);
    chk("R2 11 fall", cap_b, 16'h0666);

    // R7 counter disabled holds zero, enabled counts both edges
    do_reset();
    toggle(); toggle(); tick(3);
    chk("R7 held zero", edge_cnt, 0);
    pre_en = 1'b1; pre_cmp = 8'd10;
    toggle(); toggle(); toggle(); tick(3);
    chk("R7 counts both", edge_cnt, 3);

    // R8 R9 prescaled capture with compare 4
    do_reset(); pre_en = 1'b1; pre_cmp = 8'd4; src_sel = 1'b1; arm();
    tstamp = 16'h0C0C;
    toggle(); toggle(); toggle(); tick(3);
    chk("R9 no capture before count", flag_a, 0);
    chk("R8 count 3", edge_cnt, 3);
    toggle(); tick(4);
    chk("R8 counter reset", edge_cnt, 0);
    chk("R9 pulse captured", cap_a, 16'h0C0C);
    chk("R9 flag from pulse", flag_a, 1);

    // R8 compare 0 gives 256 edges
    do_reset(); pre_en = 1'b1; pre_cmp = 8'd0; src_sel = 1'b1; arm();
    tstamp = 16'h0D0D;
    for (int k = 0; k < 255; k++) toggle();
    tick(3);
    chk("R8 255 edges", edge_cnt, 255);
    chk("R8 no pulse at 255", flag_a, 0);
    toggle(); tick(4);
    chk("R8 256th edge", cap_a, 16'h0D0D);
    chk("R8 wrap", edge_cnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule